// File: doc/BRIEF.md
# Sequence Feeder with Replay Store

This block sits between a host that delivers packed 32-bit words and a linear array of comparison cells that consumes one character per transfer. Each sequence from the host opens with a header word that gives its character count, a keep bit and a slot number. The characters that follow are carried four to a word. The block unpacks them and sends them out one at a time over a valid/ready output. After the last character it sends a single end-of-sequence token, which downstream cells use to stop forwarding.

When the keep bit is set, the block writes a copy of the sequence into a local slot. A replay command that names a slot later re-emits the stored characters and an end token, with no new traffic from the host. This serves multi-pass comparison when the query is longer than the array. The block never waits for alignment results. Only output backpressure can stall it, so a new sequence can stream in while earlier results are still draining downstream.

Top module: `seq_feeder`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` and `ovf_flag` are low. Once the internal reset has been released and no replay is requested, `in_ready` is high and the block waits for a header.
- R2: A header word carries the character count in bits 15:0, the keep bit in bit 16 and the slot number starting at bit 17. Within each data word the character in bits 7:0 is sent first, then bits 15:8, then 23:16, then 31:24.
- R3: Exactly the number of characters given in the header is sent. Unused byte slots of a partial final word are dropped, and the host word after the last data word is taken as the next header.
- R4: After the last character of every sequence, one token with `out_eos`=1 and `out_char`=0 is sent. A header count of zero produces only that token.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_char` and `out_eos` hold their values. Across any pattern of stalls, no item is dropped or repeated.
- R6: A replay command for a slot sends that slot's stored characters in their original order, followed by one end token.
- R7: A replay command is taken in preference to a waiting host header, and `in_ready` stays low from that command until its end token has been sent. The two handshakes never complete in the same cycle.
- R8: A kept sequence may have up to DEPTH (512) characters, and a count of exactly DEPTH is stored. A kept sequence with a count above DEPTH is still streamed in full. In that case `ovf_flag` pulses for one cycle, one cycle after the header is accepted, and the slot is left empty, so a replay of it sends only the end token.
- R9: A sequence without the keep bit, or one kept in another slot, leaves a slot's stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host word valid |
| in_ready | output | 1 | Block can take a host word |
| in_data | input | 32 | Header or packed characters |
| rp_valid | input | 1 | Replay command valid |
| rp_ready | output | 1 | Replay command accepted |
| rp_slot | input | SLOT_W | Slot to replay |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Array can take an item |
| out_char | output | 8 | Output character |
| out_eos | output | 1 | Item is the end-of-sequence token |
| ovf_flag | output | 1 | One-cycle pulse for a kept sequence that is too long |

## Verification
A character becomes visible on the output one cycle after the clock edge that accepts the word holding it, or the edge that accepts the replay command. Each later item follows on every edge where `out_ready` was high. The end token comes one transfer after the last character. `ovf_flag` rises one cycle after the header handshake and lasts one cycle.

Rather than predicting absolute cycles, the bench drives `out_ready` half a period ahead of each edge and judges a transfer from the output registers, which are stable at that point. Items are compared in order against a queue of expected items. The flag is sampled once per cycle and counted against the number of oversize kept headers.

// File: rtl/seqfeed_pkg.sv
package seqfeed_pkg;
  localparam int CHAR_W  = 8;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 16;
  localparam int HDR_KEEP_BIT = 16;
  localparam int HDR_SLOT_LSB = 17;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOST,
    ST_HOST_END,
    ST_PLAY,
    ST_PLAY_END
  } feed_state_t;
endpackage

// File: rtl/seqfeed_unpack.sv
module seqfeed_unpack #(
  parameter int WORD_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              step,
  input  logic              trim,
  output logic              w_vld,
  output logic [CHAR_W-1:0] cur_char,
  output logic              at_last
);
  localparam int NCH = WORD_W / CHAR_W;
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1;

  logic [WORD_W-1:0] word_q;
  logic [IW-1:0]     idx_q, idx_d;
  logic              vld_q, vld_d;
  logic [CHAR_W-1:0] lane [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane[g] = word_q[g*CHAR_W +: CHAR_W];
  end

  assign cur_char = lane[idx_q];
  assign at_last  = (idx_q == IW'(NCH - 1));
  assign w_vld    = vld_q;

  always_comb begin
    vld_d = vld_q;
    idx_d = idx_q;
    if (load) begin
      vld_d = 1'b1;
      idx_d = '0;
    end else if (step) begin
      if (trim || at_last) begin
        vld_d = 1'b0;
        idx_d = '0;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      vld_q <= vld_d;
      idx_q <= idx_d;
      if (load) word_q <= din;
    end
  end
endmodule

// File: rtl/seqfeed_store.sv
module seqfeed_store #(
  parameter int SLOTS  = 2,
  parameter int DEPTH  = 512,
  parameter int CHAR_W = 8,
  parameter int LEN_W  = 16,
  parameter int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_slot,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic              clr_en,
  input  logic [SW-1:0]     clr_slot,
  input  logic              set_en,
  input  logic [SW-1:0]     set_slot,
  input  logic [LEN_W-1:0]  set_len,
  input  logic [SW-1:0]     rd_slot,
  input  logic [AW-1:0]     rd_addr,
  output logic [CHAR_W-1:0] rd_char,
  input  logic [SW-1:0]     q_slot,
  output logic [LEN_W-1:0]  q_len
);
  logic [CHAR_W-1:0] rd_bank [SLOTS];
  logic [LEN_W-1:0]  len_q [SLOTS];
  logic [LEN_W-1:0]  len_d [SLOTS];
  logic [SLOTS-1:0]  ok_q, ok_d;

  for (genvar g = 0; g < SLOTS; g++) begin : g_bank
    logic [CHAR_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == SW'(g))) bank[wr_addr] <= wr_char;
    end
    assign rd_bank[g] = bank[rd_addr];
  end

  assign rd_char = rd_bank[rd_slot];
  assign q_len   = ok_q[q_slot] ? len_q[q_slot] : '0;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      ok_d[s]  = ok_q[s];
      len_d[s] = len_q[s];
      if (clr_en && (clr_slot == SW'(s))) begin
        ok_d[s] = 1'b0;
      end else if (set_en && (set_slot == SW'(s))) begin
        ok_d[s]  = 1'b1;
        len_d[s] = set_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= '0;
      for (int s = 0; s < SLOTS; s++) len_q[s] <= '0;
    end else begin
      ok_q <= ok_d;
      for (int s = 0; s < SLOTS; s++) len_q[s] <= len_d[s];
    end
  end
endmodule

// File: rtl/seqfeed_outreg.sv
module seqfeed_outreg #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              item_vld,
  input  logic [CHAR_W-1:0] item_char,
  input  logic              item_eos,
  input  logic              out_ready,
  output logic              take,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_eos
);
  logic vld_d;

  assign take = item_vld && (!out_valid || out_ready);

  always_comb begin
    vld_d = out_valid;
    if (take)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_char  <= '0;
      out_eos   <= 1'b0;
    end else begin
      out_valid <= vld_d;
      if (take) begin
        out_char <= item_char;
        out_eos  <= item_eos;
      end
    end
  end
endmodule

// File: rtl/seq_feeder.sv
module seq_feeder
  import seqfeed_pkg::*;
#(
  parameter int SLOTS  = 2,
  parameter int DEPTH  = 512,
  parameter int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              rp_valid,
  output logic              rp_ready,
  input  logic [SLOT_W-1:0] rp_slot,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_eos,
  output logic              ovf_flag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  feed_state_t       st_q, st_d;
  logic [LEN_W-1:0]  rem_q, rem_d, hlen_q, hlen_d, rlen_q, rlen_d;
  logic [SLOT_W-1:0] hslot_q, hslot_d, rslot_q, rslot_d;
  logic              hkeep_q, hkeep_d, ovf_q, ovf_d;
  logic [AW-1:0]     rptr_q, rptr_d;

  logic              item_vld, item_eos, take;
  logic [CHAR_W-1:0] item_char;
  logic              w_vld, at_last, word_load, step, trim;
  logic [CHAR_W-1:0] cur_char, rd_char;
  logic              wr_en, clr_en, set_en;
  logic [AW-1:0]     wr_addr;
  logic [LEN_W-1:0]  q_len, hdr_len;
  logic [SLOT_W-1:0] hdr_slot;
  logic              hdr_keep, too_long;

  assign hdr_len  = in_data[LEN_W-1:0];
  assign hdr_keep = in_data[HDR_KEEP_BIT];
  assign hdr_slot = in_data[HDR_SLOT_LSB +: SLOT_W];
  assign too_long = hdr_len > LEN_W'(DEPTH);

  // item offered to the output register
  always_comb begin
    item_vld  = 1'b0;
    item_eos  = 1'b0;
    item_char = '0;
    case (st_q)
      ST_HOST: begin
        item_vld  = w_vld;
        item_char = cur_char;
      end
      ST_PLAY: begin
        item_vld  = 1'b1;
        item_char = rd_char;
      end
      ST_HOST_END, ST_PLAY_END: begin
        item_vld = 1'b1;
        item_eos = 1'b1;
      end
      default: ;
    endcase
  end

  // sequencing, handshakes and counters
  always_comb begin
    st_d      = st_q;
    rem_d     = rem_q;
    hlen_d    = hlen_q;
    hslot_d   = hslot_q;
    hkeep_d   = hkeep_q;
    rlen_d    = rlen_q;
    rslot_d   = rslot_q;
    rptr_d    = rptr_q;
    ovf_d     = 1'b0;
    in_ready  = 1'b0;
    rp_ready  = 1'b0;
    word_load = 1'b0;
    step      = 1'b0;
    trim      = 1'b0;
    wr_en     = 1'b0;
    clr_en    = 1'b0;
    set_en    = 1'b0;
    wr_addr   = AW'(hlen_q - rem_q);
    case (st_q)
      ST_IDLE: begin
        rp_ready = rst_i_n;
        in_ready = rst_i_n && !rp_valid;
        if (rp_valid && rst_i_n) begin
          rslot_d = rp_slot;
          rlen_d  = q_len;
          rptr_d  = '0;
          st_d    = (q_len == '0) ? ST_PLAY_END : ST_PLAY;
        end else if (in_valid && rst_i_n) begin
          hlen_d  = hdr_len;
          rem_d   = hdr_len;
          hslot_d = hdr_slot;
          hkeep_d = hdr_keep && !too_long;
          ovf_d   = hdr_keep && too_long;
          clr_en  = hdr_keep;
          st_d    = (hdr_len == '0) ? ST_HOST_END : ST_HOST;
        end
      end
      ST_HOST: begin
        in_ready  = !w_vld || (take && at_last && (rem_q > LEN_W'(1)));
        word_load = in_valid && in_ready;
        step      = take;
        trim      = (rem_q == LEN_W'(1));
        if (take) begin
          rem_d = rem_q - LEN_W'(1);
          wr_en = hkeep_q;
          if (rem_q == LEN_W'(1)) st_d = ST_HOST_END;
        end
      end
      ST_HOST_END: begin
        if (take) begin
          set_en = hkeep_q;
          st_d   = ST_IDLE;
        end
      end
      ST_PLAY: begin
        if (take) begin
          if ({{(LEN_W-AW){1'b0}}, rptr_q} + LEN_W'(1) == rlen_q) st_d = ST_PLAY_END;
          else rptr_d = rptr_q + AW'(1);
        end
      end
      ST_PLAY_END: begin
        if (take) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      hlen_q  <= '0;
      hslot_q <= '0;
      hkeep_q <= 1'b0;
      rlen_q  <= '0;
      rslot_q <= '0;
      rptr_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      rem_q   <= rem_d;
      hlen_q  <= hlen_d;
      hslot_q <= hslot_d;
      hkeep_q <= hkeep_d;
      rlen_q  <= rlen_d;
      rslot_q <= rslot_d;
      rptr_q  <= rptr_d;
      ovf_q   <= ovf_d;
    end
  end

  assign ovf_flag = ovf_q;

  seqfeed_unpack #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (word_load),
    .din      (in_data),
    .step     (step),
    .trim     (trim),
    .w_vld    (w_vld),
    .cur_char (cur_char),
    .at_last  (at_last)
  );

  seqfeed_store #(
    .SLOTS(SLOTS), .DEPTH(DEPTH), .CHAR_W(CHAR_W), .LEN_W(LEN_W),
    .SW(SLOT_W), .AW(AW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (wr_en),
    .wr_slot  (hslot_q),
    .wr_addr  (wr_addr),
    .wr_char  (cur_char),
    .clr_en   (clr_en),
    .clr_slot (hdr_slot),
    .set_en   (set_en),
    .set_slot (hslot_q),
    .set_len  (hlen_q),
    .rd_slot  (rslot_q),
    .rd_addr  (rptr_q),
    .rd_char  (rd_char),
    .q_slot   (rp_slot),
    .q_len    (q_len)
  );

  seqfeed_outreg #(.CHAR_W(CHAR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .item_vld  (item_vld),
    .item_char (item_char),
    .item_eos  (item_eos),
    .out_ready (out_ready),
    .take      (take),
    .out_valid (out_valid),
    .out_char  (out_char),
    .out_eos   (out_eos)
  );
endmodule

// File: rtl/seqfeed_chk.sv
module seqfeed_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       rp_valid,
  input logic       rp_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_char,
  input logic       out_eos,
  input logic       ovf_flag
);
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_char) && $stable(out_eos));

  // R4
  eos_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eos |-> out_char == 8'h00);

  // R7
  one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && rp_valid && rp_ready));

  // R7
  host_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid && rp_ready |=> !in_ready);

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> $past(in_valid && in_ready));

  // R8
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> !ovf_flag);
endmodule

bind seq_feeder seqfeed_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .rp_valid  (rp_valid),
  .rp_ready  (rp_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_char  (out_char),
  .out_eos   (out_eos),
  .ovf_flag  (ovf_flag)
);

// File: tb/seq_feeder_bench.sv
module seq_feeder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        rp_valid = 1'b0;
  logic        rp_ready;
  logic [0:0]  rp_slot = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_char;
  logic        out_eos;
  logic        ovf_flag;

  always #2 clk = ~clk;

  seq_feeder u_seq_feeder (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rp_valid(rp_valid), .rp_ready(rp_ready), .rp_slot(rp_slot),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_char(out_char), .out_eos(out_eos), .ovf_flag(ovf_flag)
  );

  int chk_cnt = 0;
  int fail_cnt = 0;
  int ovf_seen = 0;
  int exp_ovf = 0;
  bit free_run = 1'b1;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] exp_c [$];
  bit         exp_e [$];
  string      exp_r [$];

  logic [7:0] mdl [2][512];
  int         mdl_len [2];

  function automatic logic [7:0] ch(int seed, int i);
    return 8'((seed * 37 + i * 11 + (i >> 3)) & 255);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
  endtask

  // monitor: choose ready for the coming edge, then judge that transfer
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = free_run ? 1'b1 : (lfsr[1:0] != 2'b00);
    if (ovf_flag) ovf_seen++;
    if (rst_n && out_valid && out_ready) begin
      if (exp_c.size() == 0) begin
        check(1'b0, "R3", "unexpected item", {out_eos, out_char}, 0);
      end else begin
        logic [7:0] ec;
        bit ee;
        string er;
        ec = exp_c.pop_front();
        ee = exp_e.pop_front();
        er = exp_r.pop_front();
        check(out_char == ec && out_eos == ee, er, "item {eos,char}",
              {out_eos, out_char}, {ee, ec});
      end
    end
  end

  task automatic plan_seq(int len, bit keep, int slot, int seed, string req);
    for (int i = 0; i < len; i++) begin
      exp_c.push_back(ch(seed, i)); exp_e.push_back(1'b0); exp_r.push_back(req);
    end
    exp_c.push_back(8'h00); exp_e.push_back(1'b1); exp_r.push_back("R4");
    if (keep) begin
      if (len > 512) begin
        mdl_len[slot] = 0;
        exp_ovf++;
      end else begin
        for (int i = 0; i < len; i++) mdl[slot][i] = ch(seed, i);
        mdl_len[slot] = len;
      end
    end
  endtask

  task automatic plan_replay(int slot);
    for (int i = 0; i < mdl_len[slot]; i++) begin
      exp_c.push_back(mdl[slot][i]); exp_e.push_back(1'b0); exp_r.push_back("R6");
    end
    exp_c.push_back(8'h00); exp_e.push_back(1'b1); exp_r.push_back("R6");
  endtask

  task automatic push_word(logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic drive_seq(int len, bit keep, int slot, int seed);
    logic [31:0] w;
    push_word(32'(len & 16'hFFFF) | (32'(keep) << 16) | (32'(slot) << 17));
    for (int b = 0; b < (len + 3) / 4; b++) begin
      w = 32'hDEAD_BEEF;
      for (int k = 0; k < 4; k++) if (b * 4 + k < len) w[k*8 +: 8] = ch(seed, b * 4 + k);
      push_word(w);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drive_replay(int slot);
    @(negedge clk);
    rp_valid = 1'b1;
    rp_slot  = 1'(slot);
    #1;
    while (!rp_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    rp_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_c.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic seq(int len, bit keep, int slot, int seed, string req);
    plan_seq(len, keep, slot, seed, req);
    drive_seq(len, keep, slot, seed);
    drain();
  endtask

  task automatic replay(int slot);
    plan_replay(slot);
    drive_replay(slot);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      report();
      $finish;
    end
  end

  initial begin
    mdl_len[0] = 0;
    mdl_len[1] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(ovf_flag == 1'b0, "R1", "ovf_flag in reset", ovf_flag, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready idle", in_ready, 1);
    check(ovf_flag == 1'b0, "R1", "ovf_flag after reset", ovf_flag, 0);

    // R2 byte order and R3 trimming of partial words, free-running output
    seq(8, 1'b0, 0, 1, "R2");
    seq(5, 1'b0, 0, 2, "R3");
    seq(6, 1'b0, 0, 3, "R3");
    seq(7, 1'b0, 0, 4, "R3");
    // R4: empty sequence gives only the end token
    seq(0, 1'b0, 0, 5, "R4");

    // R5: random backpressure from here on
    free_run = 1'b0;
    seq(23, 1'b0, 0, 6, "R5");
    // R6: store two slots and replay them
    seq(10, 1'b1, 0, 7, "R6");
    seq(13, 1'b1, 1, 8, "R6");
    replay(0);
    replay(1);
    // R9: a plain sequence leaves slot 0 intact
    seq(11, 1'b0, 0, 9, "R9");
    replay(0);

    // R8: exact capacity is kept
    seq(512, 1'b1, 1, 10, "R8");
    replay(1);
    check(ovf_seen == exp_ovf, "R8", "ovf pulses at capacity", ovf_seen, exp_ovf);
    // R8: one over capacity streams through, flags, empties slot 0
    seq(513, 1'b1, 0, 11, "R8");
    check(ovf_seen == exp_ovf, "R8", "ovf pulses after oversize", ovf_seen, exp_ovf);
    replay(0);
    // R9: slot 1 survives the oversize write to slot 0
    replay(1);

    // R7: replay and host header requested together; replay goes first
    seq(9, 1'b1, 0, 12, "R7");
    plan_replay(0);
    plan_seq(6, 1'b0, 0, 13, "R7");
    fork
      drive_replay(0);
      drive_seq(6, 1'b0, 0, 13);
    join
    drain();

    check(exp_c.size() == 0, "R3", "items left unsent", exp_c.size(), 0);
    check(ovf_seen == exp_ovf, "R8", "total ovf pulses", ovf_seen, exp_ovf);
    done = 1'b1;
    report();
    $finish;
  end
endmodule